// File: doc/BRIEF.md
# 28-bit Timer/Counter with Register Access

This block is one timer/counter channel. A 28-bit up-counter advances on prescaled ticks of the bus clock while its run bit is set. On every tick the counter either steps by one or wraps to zero. A wrap happens when the next value would equal the programmed end value, or when the count steps past its all-ones value. Every wrap sets a sticky pending flag. The pending flag drives the interrupt output when the interrupt enable is also set.

A mode bit sets what happens after a wrap. In one-shot mode the block clears its own run bit and stays at zero. In free-running mode it keeps counting from zero, which gives a periodic interrupt every end-value ticks.

Software uses four word registers on a plain 32-bit bus:
- end value
- live count
- control
- interrupt enable/status

Writes are accepted on every cycle. There is no back-pressure and no ready signal. Read data is a combinational function of the address.

Top module: `cnt28_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: The count changes only on a tick or a count write. A tick requires the run bit (control bit 28) to be set. Writing 0 to the control register stops counting, and the count then holds.
- R3: The divisor d in control bits 15:0 makes the count advance once every d clocks, and d of 0 or 1 means every clock. The divider restarts on every control write, and the edge of that write never ticks.
- R4: An end-value wrap happens on a tick where count+1 equals the end value (word 0, byte offset 0x0). The count becomes 0 and the pending flag is set. An end value of 0 therefore gives the full 2^28 range.
- R5: A tick at count 0x0FFFFFFF returns the count to 0 and sets the pending flag, the same as an end-value wrap.
- R6: Control bit 24 selects the mode. At 0 (one-shot) a wrap clears the run bit and the count stays 0. At 1 (free-running) the block keeps counting from 0.
- R7: In the interrupt register (offset 0xC), bit 20 is the enable and bit 16 is the pending flag. Writing 1 to bit 16 clears pending, and writing 0 there leaves it unchanged. `irq_o` is pending AND enable.
- R8: The pending flag stays set until it is cleared by a write, even when the interrupt is disabled or the counter is stopped.
- R9: A wrap in the same cycle as a clear of the pending flag leaves the flag set.
- R10: A write to the count register (offset 0x4) loads the count on that edge. The write takes priority over a tick in the same cycle.
- R11: Reads are selected by `bus_addr[3:2]`. The count reads zero-extended, and the end value reads in bits 27:0. Control reads bits 28, 24 and 15:0, and the interrupt register reads bits 20 and 16. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are the 28-bit overflow and a wrap that lands on the same edge as a software clear. Running 2^28 cycles to reach overflow is out of reach. The bench instead presets the count a few steps below all-ones, with an end value of 0, so overflow arrives in two clocks. For the collision case, the bench counts edges from the control write, using a short end value and a divisor of 1. It then issues the clear on exactly the edge of the wrap, and compares the result with a clear one cycle later.

// File: rtl/cnt28_pkg.sv
package cnt28_pkg;
  // word indices selected by bus_addr[3:2]
  localparam logic [1:0] W_END  = 2'd0;
  localparam logic [1:0] W_CNT  = 2'd1;
  localparam logic [1:0] W_CTRL = 2'd2;
  localparam logic [1:0] W_IRQ  = 2'd3;

  // bit positions software relies on
  localparam int B_RUN  = 28;
  localparam int B_MODE = 24;
  localparam int B_IEN  = 20;
  localparam int B_PEND = 16;

  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_FREE    = 1'b1
  } tmode_e;
endpackage

// File: rtl/cnt28_prescale.sv
module cnt28_prescale #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] pcnt;
  logic          at_last;

  always_comb begin
    at_last = (div <= DW'(1)) || (pcnt == div - DW'(1));
    tick    = run && !restart && at_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pcnt <= '0;
    else if (restart || !run || tick) pcnt <= '0;
    else                              pcnt <= pcnt + DW'(1);
  end

  // R3
  prescale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > DW'(1)) |=> !tick);
endmodule

// File: rtl/cnt28_core.sv
module cnt28_core #(
  parameter int CW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] end_val,
  output logic [CW-1:0] count,
  output logic          wrap
);
  logic [CW-1:0] step;
  logic          at_top;

  always_comb begin
    step   = count + CW'(1);
    at_top = &count;
    wrap   = tick && !load && (at_top || step == end_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (wrap) count <= '0;
    else if (tick) count <= step;
  end

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));
  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/cnt28_irqflag.sv
module cnt28_irqflag (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic cfg_wr,
  input  logic en_in,
  input  logic clr_in,
  output logic en,
  output logic pend,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (cfg_wr) en <= en_in;
      if (wrap)                  pend <= 1'b1;
      else if (cfg_wr && clr_in) pend <= 1'b0;
    end
  end

  assign irq = en & pend;

  // R9
  wrap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> pend);
  // R8
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(cfg_wr && clr_in)) |=> pend);
endmodule

// File: rtl/cnt28_timer.sv
module cnt28_timer
  import cnt28_pkg::*;
#(
  parameter int CW = 28,
  parameter int DW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o
);
  localparam int PADW = 32 - CW;

  logic [1:0]    widx;
  logic          end_wr, cnt_wr, ctrl_wr, irq_wr;
  logic          run;
  tmode_e        mode;
  logic [DW-1:0] div;
  logic [CW-1:0] end_val, count;
  logic          tick, wrap, ien, pend;

  always_comb begin
    widx    = bus_addr[3:2];
    end_wr  = bus_wr && (widx == W_END);
    cnt_wr  = bus_wr && (widx == W_CNT);
    ctrl_wr = bus_wr && (widx == W_CTRL);
    irq_wr  = bus_wr && (widx == W_IRQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      mode <= MODE_ONESHOT;
      div  <= '0;
    end else if (ctrl_wr) begin
      run  <= bus_wdata[B_RUN];
      mode <= tmode_e'(bus_wdata[B_MODE]);
      div  <= bus_wdata[DW-1:0];
    end else if (wrap && mode == MODE_ONESHOT) begin
      run  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      end_val <= '0;
    else if (end_wr) end_val <= bus_wdata[CW-1:0];
  end

  cnt28_prescale #(.DW(DW)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (ctrl_wr),
    .div     (div),
    .tick    (tick)
  );

  cnt28_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (cnt_wr),
    .load_val (bus_wdata[CW-1:0]),
    .end_val  (end_val),
    .count    (count),
    .wrap     (wrap)
  );

  cnt28_irqflag u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrap   (wrap),
    .cfg_wr (irq_wr),
    .en_in  (bus_wdata[B_IEN]),
    .clr_in (bus_wdata[B_PEND]),
    .en     (ien),
    .pend   (pend),
    .irq    (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (widx)
      W_END:  bus_rdata = {{PADW{1'b0}}, end_val};
      W_CNT:  bus_rdata = {{PADW{1'b0}}, count};
      W_CTRL: begin
        bus_rdata[B_RUN]  = run;
        bus_rdata[B_MODE] = mode;
        bus_rdata[DW-1:0] = div;
      end
      default: begin
        bus_rdata[B_IEN]  = ien;
        bus_rdata[B_PEND] = pend;
      end
    endcase
  end

  // R6
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && mode == MODE_ONESHOT && !ctrl_wr) |=> !run);
  // R6
  free_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && mode == MODE_FREE && !ctrl_wr) |=> run);
endmodule

// File: tb/sim_cnt28_timer.sv
module sim_cnt28_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] A_END = 2'd0, A_CNT = 2'd1, A_CTRL = 2'd2, A_IRQ = 2'd3;
  localparam logic [31:0] PEND_B = 32'h0001_0000, IEN_B = 32'h0010_0000;

  typedef struct packed {
    logic [27:0] start;
    logic [27:0] endv;
    logic [15:0] div;
    logic        free;
    logic [15:0] n;
    logic [27:0] ecnt;
    logic        epend;
    logic        erun;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{28'd0,         28'd5,  16'd1, 1'b1, 16'd3,  28'd3,         1'b0, 1'b1},
    '{28'd0,         28'd5,  16'd1, 1'b1, 16'd5,  28'd0,         1'b1, 1'b1},
    '{28'd0,         28'd5,  16'd1, 1'b1, 16'd7,  28'd2,         1'b1, 1'b1},
    '{28'd0,         28'd5,  16'd1, 1'b0, 16'd7,  28'd0,         1'b1, 1'b0},
    '{28'd0,         28'd10, 16'd4, 1'b1, 16'd13, 28'd3,         1'b0, 1'b1},
    '{28'd0,         28'd10, 16'd0, 1'b1, 16'd4,  28'd4,         1'b0, 1'b1},
    '{28'd0,         28'd3,  16'd2, 1'b0, 16'd5,  28'd2,         1'b0, 1'b1},
    '{28'd0,         28'd3,  16'd2, 1'b0, 16'd20, 28'd0,         1'b1, 1'b0},
    '{28'h0FFFFFFE,  28'd0,  16'd1, 1'b1, 16'd1,  28'h0FFFFFFF,  1'b0, 1'b1},
    '{28'h0FFFFFFE,  28'd0,  16'd1, 1'b1, 16'd2,  28'd0,         1'b1, 1'b1}
  };

  cnt28_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    bus_addr  = {idx, 2'b00};
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] v);
    bus_addr = {idx, 2'b00};
    #1;
    v = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic prep(input logic [27:0] start, input logic [27:0] endv, input logic [31:0] cw);
    wr(A_CTRL, 32'h0);
    wr(A_IRQ, PEND_B | IEN_B);
    wr(A_CNT, {4'h0, start});
    wr(A_END, {4'h0, endv});
    wr(A_CTRL, cw);
  endtask

  function automatic logic [31:0] cword(input logic free, input logic [15:0] div);
    return 32'h1000_0000 | ({31'h0, free} << 24) | {16'h0, div};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset irq", {31'h0, irq_o}, 32'h0);

    // table walk: R3 R4 R5 R6
    for (int k = 0; k < 10; k++) begin
      prep(VECS[k].start, VECS[k].endv, cword(VECS[k].free, VECS[k].div));
      repeat (int'(VECS[k].n)) @(negedge clk);
      rd(A_CNT, v);
      chk("R3/R4/R5 count", v, {4'h0, VECS[k].ecnt});
      rd(A_IRQ, v);
      chk("R4/R5 pending", {31'h0, v[16]}, {31'h0, VECS[k].epend});
      rd(A_CTRL, v);
      chk("R6 run bit", {31'h0, v[28]}, {31'h0, VECS[k].erun});
    end

    // R7 R8: irq follows pending and enable; masking keeps pending
    prep(28'd0, 28'd2, cword(1'b0, 16'd1));
    repeat (4) @(negedge clk);
    chk("R7 irq with enable and pending", {31'h0, irq_o}, 32'h1);
    wr(A_IRQ, 32'h0);
    rd(A_IRQ, v);
    chk("R8 pending kept after disable", v, PEND_B);
    chk("R7 irq masked", {31'h0, irq_o}, 32'h0);
    wr(A_IRQ, PEND_B);
    rd(A_IRQ, v);
    chk("R7 write-one clears pending", v, 32'h0);

    // R9: clear lands on the wrap edge
    prep(28'd0, 28'd2, cword(1'b1, 16'd1));
    @(negedge clk);
    wr(A_IRQ, PEND_B | IEN_B);
    rd(A_IRQ, v);
    chk("R9 wrap beats clear", {31'h0, v[16]}, 32'h1);
    rd(A_CNT, v);
    chk("R9 count at wrap", v, 32'h0);
    wr(A_IRQ, PEND_B | IEN_B);
    rd(A_IRQ, v);
    chk("R7 clear without wrap", {31'h0, v[16]}, 32'h0);

    // R2: stop holds count
    prep(28'd0, 28'd100, cword(1'b1, 16'd1));
    repeat (3) @(negedge clk);
    wr(A_CTRL, 32'h0);
    repeat (5) @(negedge clk);
    rd(A_CNT, v);
    chk("R2 count held after stop", v, 32'd3);

    // R10: load while running
    prep(28'd0, 28'd1000, cword(1'b1, 16'd1));
    repeat (2) @(negedge clk);
    wr(A_CNT, 32'd500);
    rd(A_CNT, v);
    chk("R10 load beats tick", v, 32'd500);
    @(negedge clk);
    rd(A_CNT, v);
    chk("R10 counting after load", v, 32'd501);

    // R3: control write restarts divider
    prep(28'd0, 28'd100, cword(1'b1, 16'd4));
    repeat (2) @(negedge clk);
    wr(A_CTRL, cword(1'b1, 16'd4));
    repeat (3) @(negedge clk);
    rd(A_CNT, v);
    chk("R3 divider restarted", v, 32'd0);
    @(negedge clk);
    rd(A_CNT, v);
    chk("R3 tick after restart", v, 32'd1);

    // R11: unused bits read 0
    wr(A_CTRL, 32'h0);
    wr(A_END, 32'hFFFF_FFFF);
    rd(A_END, v);
    chk("R11 end value width", v, 32'h0FFF_FFFF);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v);
    chk("R11 control fields", v, 32'h1100_FFFF);
    wr(A_CTRL, 32'h0);
    wr(A_IRQ, 32'hFFFF_FFFF);
    rd(A_IRQ, v);
    chk("R11 interrupt fields", v & ~PEND_B, IEN_B);
    wr(A_CNT, 32'hFFFF_FFFF);
    rd(A_CNT, v);
    chk("R11 count zero-extended", v, 32'h0FFF_FFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule